// File: doc/BRIEF.md
# LCD Frame Fetch and Palette Sequencer

This block runs the per-frame control sequence of a display controller that scans its picture out of a frame buffer in memory. At each frame tick it can read a 256-entry table of 16-bit colour words from the start of the current buffer into an internal palette store. The first of those words carries a code that selects the pixel depth. From that code the block works out where the pixel data begins, how many bytes each line takes, and whether the whole frame fits inside the buffer window that has been programmed. A frame that fits is accepted and its fetch parameters are handed on. A frame that does not fit is aborted, and the block turns itself off.

Two buffer windows can be programmed. In dual mode the sequencer alternates between them after every accepted frame. When the enable input rises, the block checks the window addresses against the size of the memory map. A sub-panel control word can restrict the visible region, either by a start line or by a line count. The size product width x height x depth is formed by a shift-and-add multiplier that takes several cycles, so the block contains no wide combinational multiplier. A downstream pixel engine uses the latched outputs. It is not part of this block.

Top module: `lcd_frame_seq`

## Requirements
- R1: On a frame tick while active, and with load mode not 1 and not 2, the block issues exactly 256 single 16-bit reads at byte addresses top, top+2, ..., top+510 of the current buffer, with one request outstanding at a time. Entry i is stored and can be read back on `pal_rd_data` when `pal_rd_idx`=i.
- R2: `pal_done` pulses exactly once per palette load, in the cycle after the response for the last entry arrives.
- R3: The depth code is bits 14:12 of palette entry 0. Codes 1, 2 and 3 give `bpp_out` 2, 4 and 8, and codes 4 to 7 give 16. Code 0 skips the frame with no event. The data offset is 0x200 for codes 3 and above and 0x20 for codes 1 and 2. With load mode 2 no reads occur, the offset is 0 and the code stored by the last palette load is used. `pix_base` = buffer top + offset.
- R4: When offset + width*height*bpp/8 > bottom - top + 2, `sync_err` pulses, `active` drops in the same cycle and no `frame_done` is given. A frame of exactly bottom - top + 2 bytes is accepted.
- R5: An accepted frame pulses `frame_done` together with `cond[b]`, where b is the buffer used (bit 0 or bit 1). `dma_irq` pulses with it when `irq_mask[0]` is 1.
- R6: In dual mode the buffer toggles after every accepted frame, starting from buffer 0 at enable. In single mode buffer 0 is always used.
- R7: On a rising `enable`, if a top or bottom address of buffer 0 is at or above MEM_LIMIT, or one of buffer 1 is and dual mode is set, then `cond[2]` pulses, `dma_irq` pulses when `irq_mask[1]` is 1, and `active` stays 0. Buffer 1 is ignored in single mode.
- R8: With load mode 1 a frame tick causes no memory reads and no events.
- R9: If subpanel bit 31 is set, bits 25:16 give `first_line` (with `line_count` = height) when bit 29 is set, and give `line_count` (with `first_line` = 0) when bit 29 is clear. Otherwise `first_line` = 0 and `line_count` = height.
- R10: `line_stride` = width*bpp/8, with the result truncated.
- R11: After reset `active`, `mem_req`, every event output and `cond` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Level enable; a rising edge starts the address check |
| frame_start | input | 1 | One-cycle frame tick |
| load_mode | input | 2 | 0: palette and data, 1: no fetch, 2: data only |
| dual_buf | input | 1 | Alternate between the two buffers |
| irq_mask | input | 2 | Bit 0: frame interrupt, bit 1: address error interrupt |
| buf0_top | input | AW | Buffer 0 start byte address |
| buf0_bot | input | AW | Buffer 0 end byte address |
| buf1_top | input | AW | Buffer 1 start byte address |
| buf1_bot | input | AW | Buffer 1 end byte address |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| subpanel | input | 32 | Sub-panel control word |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pal_rd_idx | input | 8 | Palette read-back index |
| pal_rd_data | output | 16 | Palette read-back data |
| active | output | 1 | Sequencer is enabled |
| pal_done | output | 1 | Palette loaded pulse |
| sync_err | output | 1 | Frame overrun pulse |
| frame_done | output | 1 | Frame accepted pulse |
| cond | output | 3 | Buffer 0 / buffer 1 / address error pulses |
| dma_irq | output | 1 | Interrupt pulse |
| pix_base | output | AW | Start address of the pixel data |
| line_stride | output | DIM_W+1 | Bytes per line |
| bpp_out | output | 5 | Bits per pixel |
| first_line | output | DIM_W | First displayed line |
| line_count | output | DIM_W | Displayed lines |

## Verification
On every cycle the assertions check that the palette-loaded pulse follows exactly 256 read responses, that an accepted frame and an overrun never coincide, that an overrun or an address error leaves the block inactive, that the condition pulses are one-hot, and that memory is read only while the block is active. Only the bench scenarios can show the values that depend on memory contents and configuration: the decoded depth and offset, the exact fit boundary at bottom - top + 2, the buffer alternation, the sub-panel decoding, the stride, and the behaviour of load modes 1 and 2.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAL_REQ,
        ST_PAL_WAIT,
        ST_DECODE,
        ST_MUL,
        ST_CHECK
    } seq_state_t;

    typedef struct packed {
        logic       skip;
        logic [4:0] bpp;
        logic [2:0] lg;
        logic [9:0] offset;
    } depth_info_t;

    localparam logic [1:0] LM_NO_FETCH = 2'd1;
    localparam logic [1:0] LM_NO_PAL   = 2'd2;

    localparam int CODE_LSB     = 12;
    localparam int SP_EN_BIT    = 31;
    localparam int SP_FIRST_BIT = 29;
    localparam int SP_FIELD_LSB = 16;
    localparam int SP_FIELD_W   = 10;

    // Depth code to bits per pixel, log2 of it, and data offset.
    function automatic depth_info_t decode_depth(input logic [2:0] code,
                                                 input logic no_pal);
        depth_info_t d;
        d.skip = (code == 3'd0);
        case (code)
            3'd1:    begin d.bpp = 5'd2;  d.lg = 3'd1; end
            3'd2:    begin d.bpp = 5'd4;  d.lg = 3'd2; end
            3'd3:    begin d.bpp = 5'd8;  d.lg = 3'd3; end
            3'd0:    begin d.bpp = 5'd0;  d.lg = 3'd0; end
            default: begin d.bpp = 5'd16; d.lg = 3'd4; end
        endcase
        if (no_pal)
            d.offset = 10'd0;
        else if (code >= 3'd3)
            d.offset = 10'h200;
        else
            d.offset = 10'h020;
        return d;
    endfunction

endpackage

// File: rtl/lcd_pal_ram.sv
module lcd_pal_ram #(
    parameter int N  = 256,
    parameter int DW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lcd_shift_mul.sv
module lcd_shift_mul #(
    parameter int W = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] acc_q, mc_q;
    logic [W-1:0]   mp_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mc_q   <= '0;
            mp_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc_q  <= '0;
                mc_q   <= {{W{1'b0}}, a};
                mp_q   <= b;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (mp_q[0])
                    acc_q <= acc_q + mc_q;
                mc_q  <= mc_q << 1;
                mp_q  <= mp_q >> 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;
endmodule

// File: rtl/lcd_fit_check.sv
module lcd_fit_check #(
    parameter int AW    = 24,
    parameter int DIM_W = 10,
    localparam int PW = 2 * DIM_W,
    localparam int CW = ((AW > PW + 1) ? AW : PW + 1) + 2
) (
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] bot,
    input  logic [9:0]    offset,
    input  logic [PW-1:0] prod,
    input  logic [2:0]    lg,
    output logic          fits
);
    logic [CW-1:0] bytes, lhs, rhs;

    // offset + bytes > bot - top + 2 rewritten without subtraction.
    always_comb begin
        bytes = (CW'(prod) << lg) >> 3;
        lhs   = CW'(top) + CW'(offset) + bytes;
        rhs   = CW'(bot) + CW'(2);
        fits  = !(lhs > rhs);
    end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DIM_W     = 10,
    parameter int PAL_N     = 256,
    parameter int MEM_LIMIT = 1 << 20,
    localparam int IW = $clog2(PAL_N),
    localparam int PW = 2 * DIM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             frame_start,
    input  logic [1:0]       load_mode,
    input  logic             dual_buf,
    input  logic [1:0]       irq_mask,
    input  logic [AW-1:0]    buf0_top,
    input  logic [AW-1:0]    buf0_bot,
    input  logic [AW-1:0]    buf1_top,
    input  logic [AW-1:0]    buf1_bot,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic [31:0]      subpanel,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [15:0]      mem_rdata,
    input  logic [IW-1:0]    pal_rd_idx,
    output logic [15:0]      pal_rd_data,
    output logic             active,
    output logic             pal_done,
    output logic             sync_err,
    output logic             frame_done,
    output logic [2:0]       cond,
    output logic             dma_irq,
    output logic [AW-1:0]    pix_base,
    output logic [DIM_W:0]   line_stride,
    output logic [4:0]       bpp_out,
    output logic [DIM_W-1:0] first_line,
    output logic [DIM_W-1:0] line_count
);
    localparam logic [AW:0]   LIMIT    = (AW + 1)'(MEM_LIMIT);
    localparam logic [IW-1:0] LAST_IDX = IW'(PAL_N - 1);

    seq_state_t    state_q;
    logic          en_q;
    logic          cur_buf_q;
    logic [IW-1:0] idx_q;
    logic [2:0]    code_q;

    logic [AW-1:0] cur_top, cur_bot;
    depth_info_t   dinfo;
    logic          addr_bad;
    logic          mul_start, mul_done, fits;
    logic [PW-1:0] mul_prod;
    logic          ram_we;
    logic [DIM_W+4:0] stride_wide;
    logic [SP_FIELD_W-1:0] sp_field;
    logic          unused_sp;

    assign cur_top   = cur_buf_q ? buf1_top : buf0_top;
    assign cur_bot   = cur_buf_q ? buf1_bot : buf0_bot;
    assign dinfo     = decode_depth(code_q, load_mode == LM_NO_PAL);
    assign mul_start = (state_q == ST_DECODE) && !dinfo.skip;
    assign mem_req   = (state_q == ST_PAL_REQ);
    assign ram_we    = (state_q == ST_PAL_WAIT) && mem_rvalid;
    assign sp_field  = subpanel[SP_FIELD_LSB +: SP_FIELD_W];
    assign stride_wide = ((DIM_W + 5)'(width) << dinfo.lg) >> 3;
    assign unused_sp = ^{subpanel[30], subpanel[28:26], subpanel[15:0], stride_wide[DIM_W+4:DIM_W+1]};

    always_comb begin
        addr_bad = ({1'b0, buf0_top} >= LIMIT) || ({1'b0, buf0_bot} >= LIMIT);
        if (dual_buf && (({1'b0, buf1_top} >= LIMIT) || ({1'b0, buf1_bot} >= LIMIT)))
            addr_bad = 1'b1;
    end

    lcd_pal_ram #(.N(PAL_N), .DW(16)) u_pal (
        .clk   (clk),
        .we    (ram_we),
        .waddr (idx_q),
        .wdata (mem_rdata),
        .raddr (pal_rd_idx),
        .rdata (pal_rd_data)
    );

    lcd_shift_mul #(.W(DIM_W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (mul_start),
        .a     (width),
        .b     (height),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    lcd_fit_check #(.AW(AW), .DIM_W(DIM_W)) u_fit (
        .top    (cur_top),
        .bot    (cur_bot),
        .offset (dinfo.offset),
        .prod   (mul_prod),
        .lg     (dinfo.lg),
        .fits   (fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            en_q        <= 1'b0;
            active      <= 1'b0;
            cur_buf_q   <= 1'b0;
            idx_q       <= '0;
            code_q      <= '0;
            mem_addr    <= '0;
            pal_done    <= 1'b0;
            sync_err    <= 1'b0;
            frame_done  <= 1'b0;
            cond        <= '0;
            dma_irq     <= 1'b0;
            pix_base    <= '0;
            line_stride <= '0;
            bpp_out     <= '0;
            first_line  <= '0;
            line_count  <= '0;
        end else begin
            pal_done   <= 1'b0;
            sync_err   <= 1'b0;
            frame_done <= 1'b0;
            cond       <= '0;
            dma_irq    <= 1'b0;
            en_q       <= enable;
            if (!enable) begin
                active  <= 1'b0;
                state_q <= ST_IDLE;
            end else if (!en_q) begin
                state_q   <= ST_IDLE;
                cur_buf_q <= 1'b0;
                if (addr_bad) begin
                    cond    <= 3'b100;
                    dma_irq <= irq_mask[1];
                    active  <= 1'b0;
                end else begin
                    active <= 1'b1;
                end
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (frame_start && active && load_mode != LM_NO_FETCH) begin
                            if (load_mode == LM_NO_PAL) begin
                                state_q <= ST_DECODE;
                            end else begin
                                idx_q    <= '0;
                                mem_addr <= cur_top;
                                state_q  <= ST_PAL_REQ;
                            end
                        end
                    end
                    ST_PAL_REQ: state_q <= ST_PAL_WAIT;
                    ST_PAL_WAIT: begin
                        if (mem_rvalid) begin
                            if (idx_q == '0)
                                code_q <= mem_rdata[CODE_LSB +: 3];
                            if (idx_q == LAST_IDX) begin
                                pal_done <= 1'b1;
                                state_q  <= ST_DECODE;
                            end else begin
                                idx_q    <= idx_q + 1'b1;
                                mem_addr <= mem_addr + AW'(2);
                                state_q  <= ST_PAL_REQ;
                            end
                        end
                    end
                    ST_DECODE: state_q <= dinfo.skip ? ST_IDLE : ST_MUL;
                    ST_MUL: begin
                        if (mul_done)
                            state_q <= ST_CHECK;
                    end
                    ST_CHECK: begin
                        state_q <= ST_IDLE;
                        if (!fits) begin
                            sync_err <= 1'b1;
                            active   <= 1'b0;
                        end else begin
                            frame_done       <= 1'b1;
                            cond[cur_buf_q]  <= 1'b1;
                            dma_irq          <= irq_mask[0];
                            pix_base         <= cur_top + AW'(dinfo.offset);
                            line_stride      <= stride_wide[DIM_W:0];
                            bpp_out          <= dinfo.bpp;
                            if (subpanel[SP_EN_BIT] && subpanel[SP_FIRST_BIT]) begin
                                first_line <= DIM_W'(sp_field);
                                line_count <= height;
                            end else if (subpanel[SP_EN_BIT]) begin
                                first_line <= '0;
                                line_count <= DIM_W'(sp_field);
                            end else begin
                                first_line <= '0;
                                line_count <= height;
                            end
                            if (dual_buf)
                                cur_buf_q <= ~cur_buf_q;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk #(
    parameter int PAL_N = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       mem_req,
    input logic       mem_rvalid,
    input logic       active,
    input logic       pal_done,
    input logic       sync_err,
    input logic       frame_done,
    input logic [2:0] cond
);
    localparam int CNTW = $clog2(PAL_N + 1) + 1;
    logic [CNTW-1:0] rsp_cnt;

    always_ff @(posedge clk) begin
        if (rst || !active || pal_done)
            rsp_cnt <= '0;
        else if (mem_rvalid)
            rsp_cnt <= rsp_cnt + 1'b1;
    end

    assert_pal_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        pal_done |-> (rsp_cnt == CNTW'(PAL_N)));

    assert_req_only_active_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> active);

    assert_done_excl_err_R4: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !sync_err);

    assert_err_disables_R4: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> !active);

    assert_cond_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cond));

    assert_done_has_buf_R5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (cond[1:0] != 2'b00));

    assert_badaddr_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        cond[2] |-> !active);
endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.PAL_N(PAL_N)) u_chk (.*);

// File: tb/lcd_frame_seq_bench.sv
module lcd_frame_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 10;
    localparam int LIM = 1 << 20;

    logic clk = 0, rst = 1, enable = 0, frame_start = 0, dual_buf = 0;
    logic [1:0] load_mode = 0, irq_mask = 0;
    logic [AW-1:0] buf0_top, buf0_bot, buf1_top, buf1_bot;
    logic [DW-1:0] width, height;
    logic [31:0] subpanel = 0;
    logic mem_req, mem_rvalid = 0;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata = 0;
    logic [7:0] pal_rd_idx = 0;
    logic [15:0] pal_rd_data;
    logic active, pal_done, sync_err, frame_done, dma_irq;
    logic [2:0] cond;
    logic [AW-1:0] pix_base;
    logic [DW:0] line_stride;
    logic [4:0] bpp_out;
    logic [DW-1:0] first_line, line_count;

    logic [2:0] code0 = 1, code1 = 1;
    int vectors = 0, fails = 0;
    int n_req = 0, n_pal = 0, n_done = 0, n_err = 0, n_c0 = 0, n_c1 = 0, n_c2 = 0, n_irq = 0;
    int d_req, d_pal, d_done, d_err, d_c0, d_c1, d_c2, d_irq;
    int s_req, s_pal, s_done, s_err, s_c0, s_c1, s_c2, s_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_frame_seq u_lcd_frame_seq (.*);

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        if (a == buf0_top) return {1'b0, code0, 12'h3C5};
        if (a == buf1_top) return {1'b1, code1, 12'h5A1};
        return a[16:1] ^ 16'hC3A5;
    endfunction

    function automatic int exp_bpp(input logic [2:0] c);
        return (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 16;
    endfunction

    function automatic int exp_off(input logic [2:0] c);
        return (c >= 3) ? 'h200 : 'h20;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_word(mem_addr);
        if (mem_req) n_req++;
        if (pal_done) n_pal++;
        if (frame_done) n_done++;
        if (sync_err) n_err++;
        if (cond[0]) n_c0++;
        if (cond[1]) n_c1++;
        if (cond[2]) n_c2++;
        if (dma_irq) n_irq++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_req = n_req; s_pal = n_pal; s_done = n_done; s_err = n_err;
        s_c0 = n_c0; s_c1 = n_c1; s_c2 = n_c2; s_irq = n_irq;
    endtask

    task automatic diff();
        d_req = n_req - s_req; d_pal = n_pal - s_pal; d_done = n_done - s_done;
        d_err = n_err - s_err; d_c0 = n_c0 - s_c0; d_c1 = n_c1 - s_c1;
        d_c2 = n_c2 - s_c2; d_irq = n_irq - s_irq;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_frame();
        snap();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        wait_cyc(700);
        diff();
    endtask

    task automatic rise_enable();
        snap();
        @(negedge clk); enable = 0;
        wait_cyc(2);
        enable = 1;
        wait_cyc(3);
        diff();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic exp_buf;
        logic [AW-1:0] t;
        int b;
        void'($urandom(32'h1CD5EED));
        buf0_top = 24'h001000; buf0_bot = 24'h009000;
        buf1_top = 24'h020000; buf1_bot = 24'h030000;
        width = 16; height = 4;
        wait_cyc(5);
        rst = 0;
        wait_cyc(2);
        // R11 reset state
        chk(active == 0, "R11 active", active, 0);
        chk(mem_req == 0 && pal_done == 0 && sync_err == 0 && frame_done == 0, "R11 events",
            {mem_req, pal_done, sync_err, frame_done}, 0);
        chk(cond == 0 && dma_irq == 0, "R11 cond", cond, 0);

        // R7 invalid buffer 0 address
        irq_mask = 2'b11;
        buf0_top = 24'(LIM);
        rise_enable();
        chk(d_c2 == 1, "R7 cond2", d_c2, 1);
        chk(d_irq == 1, "R7 irq", d_irq, 1);
        chk(active == 0, "R7 inactive", active, 0);
        // R7 buffer 1 invalid ignored in single mode
        buf0_top = 24'h001000;
        buf1_top = 24'(LIM + 16);
        rise_enable();
        chk(d_c2 == 0 && active == 1, "R7 single ignores buf1", {d_c2[0], active}, 1);
        // R8 no fetch
        load_mode = 1;
        do_frame();
        chk(d_req == 0 && d_pal == 0 && d_done == 0 && d_err == 0, "R8 no fetch",
            d_req + d_pal + d_done + d_err, 0);
        load_mode = 0;
        // R7 buffer 1 invalid in dual mode
        dual_buf = 1;
        irq_mask = 2'b01;
        rise_enable();
        chk(d_c2 == 1 && d_irq == 0 && active == 0, "R7 dual buf1 bad",
            {d_c2[1:0], d_irq[0], active}, 4'b0100);
        buf1_top = 24'h020000;

        // Random dual-buffer frames: R1 R2 R3 R5 R6 R10
        rise_enable();
        exp_buf = 0;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c;
            c = 3'(1 + ($urandom % 7));
            if (exp_buf) code1 = c; else code0 = c;
            width = DW'(1 + ($urandom % 40));
            height = DW'(1 + ($urandom % 20));
            irq_mask = 2'($urandom % 4);
            do_frame();
            t = exp_buf ? buf1_top : buf0_top;
            chk(d_req == 256, "R1 read count", d_req, 256);
            chk(d_pal == 1, "R2 pal_done once", d_pal, 1);
            chk(d_done == 1 && d_err == 0, "R5 frame_done", d_done, 1);
            chk(bpp_out == 5'(exp_bpp(c)), "R3 bpp", bpp_out, exp_bpp(c));
            chk(pix_base == t + AW'(exp_off(c)), "R3 pix_base", pix_base, t + AW'(exp_off(c)));
            chk(line_stride == (DW+1)'((int'(width) * exp_bpp(c)) / 8), "R10 stride",
                line_stride, (int'(width) * exp_bpp(c)) / 8);
            chk(d_c0 == (exp_buf ? 0 : 1) && d_c1 == (exp_buf ? 1 : 0), "R6 buffer select",
                d_c1, exp_buf);
            chk(d_irq == (irq_mask[0] ? 1 : 0), "R5 irq", d_irq, irq_mask[0]);
            b = $urandom % 256;
            @(negedge clk); pal_rd_idx = 8'(b);
            #1;
            chk(pal_rd_data == mem_word(t + AW'(2 * b)), "R1 palette entry",
                pal_rd_data, mem_word(t + AW'(2 * b)));
            exp_buf = ~exp_buf;
        end

        // R3 code 0 skips
        if (exp_buf) code1 = 0; else code0 = 0;
        do_frame();
        chk(d_pal == 1 && d_done == 0 && d_err == 0, "R3 code0 skip", d_done + d_err, 0);
        // frame with code 2 then load mode 2 reuses it
        if (exp_buf) code1 = 2; else code0 = 2;
        do_frame();
        chk(d_done == 1 && bpp_out == 4, "R3 code2", bpp_out, 4);
        exp_buf = ~exp_buf;
        if (exp_buf) code1 = 6; else code0 = 6;
        load_mode = 2;
        do_frame();
        t = exp_buf ? buf1_top : buf0_top;
        chk(d_req == 0 && d_pal == 0, "R3 mode2 no reads", d_req, 0);
        chk(d_done == 1 && bpp_out == 4 && pix_base == t, "R3 mode2 offset", pix_base, t);
        exp_buf = ~exp_buf;
        load_mode = 0;

        // R9 sub-panel
        height = 12;
        subpanel = (32'h1 << 31) | (32'h1 << 29) | (32'd7 << 16) | 32'h0000BEEF;
        do_frame();
        chk(first_line == 7 && line_count == 12, "R9 first line", first_line, 7);
        subpanel = (32'h1 << 31) | (32'd3 << 16);
        do_frame();
        chk(first_line == 0 && line_count == 3, "R9 line count", line_count, 3);
        subpanel = 32'd5 << 16;
        do_frame();
        chk(first_line == 0 && line_count == 12, "R9 disabled", line_count, 12);

        // R4 fit boundary, single buffer
        dual_buf = 0;
        code0 = 3; width = 16; height = 4;
        buf0_bot = buf0_top + 24'h23E;
        rise_enable();
        do_frame();
        chk(d_done == 1 && d_err == 0 && active == 1, "R4 exact fit accepted", d_done, 1);
        chk(d_c0 == 1 && d_c1 == 0, "R6 single uses buf0", d_c1, 0);
        buf0_bot = buf0_top + 24'h23D;
        do_frame();
        chk(d_err == 1 && d_done == 0, "R4 overrun sync_err", d_err, 1);
        chk(active == 0, "R4 disabled", active, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule